// File: doc/BRIEF.md
# Byte-Program and Verify Sequencer

This block writes a complete image into a byte-wide parallel nonvolatile memory and then reads all of it back. A single start strobe launches the run. The block raises a request for the programming voltage and waits for it to settle. It then walks the address space from zero to the top address. For each address it presents the address and the byte from a data source, fires one fixed-width program strobe, and holds the bus afterwards. When the last byte is written, it keeps the voltage request up for a short hold and then drops it. After a recovery interval it turns the data bus around and reads every address back in ascending order, comparing each byte with the same data source.

The data source is combinational. It sees the block's address output and returns the intended byte on the same cycle. Every interval given in microseconds becomes a clock-cycle count, derived from the clock-frequency parameter and rounded up. No byte is retried. The array is expected to have been erased by a separate block beforehand.

When the read-back ends, the block reports done. Pass is high only if every byte matched. If any byte differed, the lowest mismatching address is reported. These results stay unchanged until the next accepted start.

Top module: `prog_verify_seq`

## Requirements
- R1: While reset is held and after it is released with no start, the block is idle: busy, done and the voltage request are low, chip-enable, output-enable and program strobe (all active low) are high, and the data driver is off.
- R2: A run writes every address once, in ascending order from 0 to 2^ADDR_W-1, with exactly one program pulse per address. Each pulse carries the data-source byte for that address on the data output.
- R3: Each program pulse (program strobe low) lasts exactly ceil(CLK_FREQ_HZ*PULSE_US/1e6) cycles. It never exceeds ceil(CLK_FREQ_HZ*PULSE_MAX_US/1e6) cycles.
- R4: Address and driven data are stable for at least ceil(CLK_FREQ_HZ*SETUP_US/1e6) cycles before each pulse begins. They also stay stable for at least that many cycles after it ends.
- R5: The voltage request rises at least ceil(CLK_FREQ_HZ*VPP_US/1e6) cycles before the first pulse and falls no earlier than that many cycles after the last pulse. It is never high while output-enable is low.
- R6: At least ceil(CLK_FREQ_HZ*RECOV_US/1e6) cycles pass between the fall of the voltage request and the first fall of output-enable.
- R7: During a pulse, output-enable is high, chip-enable is low and the data driver is on. During read-back the data driver is off.
- R8: Read-back visits every address once, in ascending order, with chip-enable and output-enable low. Each address is held for at least ACC_CYC cycles before its byte is sampled.
- R9: When done rises, pass is 1 if every sampled byte equalled the data-source byte. Otherwise pass is 0 and the failure address is the lowest mismatching address.
- R10: Done, pass and the failure address stay constant from the end of a run until the next accepted start. That start clears done on the following cycle.
- R11: A start strobe while busy is ignored. The run in progress continues unchanged, with no restart and no extra pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle strobe that begins a run when idle |
| src_data | input | DATA_W | Intended byte for the address on mem_addr |
| mem_dq_in | input | DATA_W | Data read back from the memory |
| mem_addr | output | ADDR_W | Memory address, also the data-source address |
| mem_dq_out | output | DATA_W | Data driven to the memory during programming |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_pgm_n | output | 1 | Program strobe, active low |
| vpp_en | output | 1 | Request for the programming voltage |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Result valid, held until the next start |
| pass | output | 1 | All bytes matched |
| fail_addr | output | ADDR_W | Lowest mismatching address |

## Verification
The final read-back sample at the top address and the completion of the run fall on the same clock edge. On that edge a mismatch is recorded, the sequence leaves read-back, and done rises. The bench provokes this by corrupting only the top address's read-back, and separately by corrupting both address 0 and the top address. It then judges that done appears with pass low and the failure address equal to the top address in the first case and to 0 in the second. A start strobe landing in the middle of programming is a second collision, and it is judged by an unchanged pulse count and address order.

// File: rtl/pv_pkg.sv
package pv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_VUP, ST_SETUP, ST_PULSE, ST_HOLD, ST_VDOWN, ST_RECOV, ST_READ
  } pv_state_t;

  // microseconds to clock cycles, rounded up, never below one cycle
  function automatic int unsigned us_to_cyc(int unsigned freq_hz, int unsigned us);
    longint unsigned n;
    n = (64'(freq_hz) * 64'(us) + 64'd999_999) / 64'd1_000_000;
    if (n == 64'd0) n = 64'd1;
    return 32'(n);
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pv_timer.sv
module pv_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pv_result.sv
module pv_result #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ev,
  input  logic              mism,
  input  logic [ADDR_W-1:0] ev_addr,
  output logic              fail_seen,
  output logic [ADDR_W-1:0] fail_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_seen <= 1'b0;
      fail_addr <= '0;
    end else if (clr) begin
      fail_seen <= 1'b0;
      fail_addr <= '0;
    end else if (ev && mism && !fail_seen) begin
      fail_seen <= 1'b1;
      fail_addr <= ev_addr;
    end
  end
endmodule

// File: rtl/prog_verify_seq.sv
module prog_verify_seq
  import pv_pkg::*;
#(
  parameter int unsigned ADDR_W       = 4,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CLK_FREQ_HZ  = 250_000_000,
  parameter int unsigned PULSE_US     = 20,
  parameter int unsigned PULSE_MAX_US = 30,
  parameter int unsigned SETUP_US     = 1,
  parameter int unsigned VPP_US       = 1,
  parameter int unsigned RECOV_US     = 1,
  parameter int unsigned ACC_CYC      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] src_data,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_pgm_n,
  output logic              vpp_en,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int unsigned T_PW  = us_to_cyc(CLK_FREQ_HZ, PULSE_US);
  localparam int unsigned T_SU  = us_to_cyc(CLK_FREQ_HZ, SETUP_US);
  localparam int unsigned T_VP  = us_to_cyc(CLK_FREQ_HZ, VPP_US);
  localparam int unsigned T_VR  = us_to_cyc(CLK_FREQ_HZ, RECOV_US);
  localparam int unsigned T_ACC = (ACC_CYC == 0) ? 1 : ACC_CYC;
  localparam int unsigned T_MAX = max_u(max_u(T_PW, T_SU), max_u(max_u(T_VP, T_VR), T_ACC));
  localparam int CNT_W = $clog2(T_MAX + 1) + 1;
  localparam logic [CNT_W-1:0]  L_PW  = CNT_W'(T_PW - 1);
  localparam logic [CNT_W-1:0]  L_SU  = CNT_W'(T_SU - 1);
  localparam logic [CNT_W-1:0]  L_VP  = CNT_W'(T_VP - 1);
  localparam logic [CNT_W-1:0]  L_VR  = CNT_W'(T_VR - 1);
  localparam logic [CNT_W-1:0]  L_ACC = CNT_W'(T_ACC - 1);
  localparam logic [ADDR_W-1:0] LAST  = '1;

  pv_state_t st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;
  logic              t_zero, t_load;
  logic [CNT_W-1:0]  t_val;
  logic              addr_inc, addr_clr;
  // named events for the checker
  logic              accept, rd_ev, rd_mism, run_end, fail_seen;

  assign accept  = (st_q == ST_IDLE) && start;
  assign rd_mism = (mem_dq_in != src_data);

  always_comb begin
    st_d     = st_q;
    t_load   = 1'b0;
    t_val    = '0;
    addr_inc = 1'b0;
    addr_clr = 1'b0;
    rd_ev    = 1'b0;
    run_end  = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (start) begin
                  st_d = ST_VUP; t_load = 1'b1; t_val = L_VP; addr_clr = 1'b1;
                end
      ST_VUP:   if (t_zero) begin st_d = ST_SETUP; t_load = 1'b1; t_val = L_SU; end
      ST_SETUP: if (t_zero) begin st_d = ST_PULSE; t_load = 1'b1; t_val = L_PW; end
      ST_PULSE: if (t_zero) begin st_d = ST_HOLD;  t_load = 1'b1; t_val = L_SU; end
      ST_HOLD:  if (t_zero) begin
                  t_load = 1'b1;
                  if (addr_q == LAST) begin
                    st_d = ST_VDOWN; t_val = L_VP;
                  end else begin
                    st_d = ST_SETUP; t_val = L_SU; addr_inc = 1'b1;
                  end
                end
      ST_VDOWN: if (t_zero) begin
                  st_d = ST_RECOV; t_load = 1'b1; t_val = L_VR; addr_clr = 1'b1;
                end
      ST_RECOV: if (t_zero) begin st_d = ST_READ; t_load = 1'b1; t_val = L_ACC; end
      ST_READ:  if (t_zero) begin
                  rd_ev = 1'b1;
                  if (addr_q == LAST) begin
                    st_d = ST_IDLE; run_end = 1'b1;
                  end else begin
                    t_load = 1'b1; t_val = L_ACC; addr_inc = 1'b1;
                  end
                end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (addr_clr)      addr_q <= '0;
      else if (addr_inc) addr_q <= addr_q + 1'b1;
      if (accept)        done_q <= 1'b0;
      else if (run_end)  done_q <= 1'b1;
    end
  end

  pv_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  pv_result #(.ADDR_W(ADDR_W)) u_res (
    .clk(clk), .rst_n(rst_n), .clr(accept), .ev(rd_ev), .mism(rd_mism),
    .ev_addr(addr_q), .fail_seen(fail_seen), .fail_addr(fail_addr)
  );

  assign mem_addr   = addr_q;
  assign mem_dq_out = src_data;
  assign mem_dq_oe  = (st_q == ST_SETUP) || (st_q == ST_PULSE) || (st_q == ST_HOLD);
  assign vpp_en     = mem_dq_oe || (st_q == ST_VUP) || (st_q == ST_VDOWN);
  assign mem_ce_n   = !(vpp_en || (st_q == ST_READ));
  assign mem_oe_n   = (st_q != ST_READ);
  assign mem_pgm_n  = (st_q != ST_PULSE);
  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign pass       = done_q && !fail_seen;
endmodule

// File: rtl/pv_checker.sv
module pv_checker
  import pv_pkg::*;
#(
  parameter int unsigned ADDR_W       = 4,
  parameter int unsigned CLK_FREQ_HZ  = 250_000_000,
  parameter int unsigned PULSE_US     = 20,
  parameter int unsigned PULSE_MAX_US = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              vpp_en,
  input logic              ce_n,
  input logic              oe_n,
  input logic              pgm_n,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] fail_addr,
  input logic              rd_ev
);
  localparam int unsigned PW_CYC  = us_to_cyc(CLK_FREQ_HZ, PULSE_US);
  localparam int unsigned PW_CEIL = us_to_cyc(CLK_FREQ_HZ, PULSE_MAX_US);

  int unsigned pw_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pw_cnt <= 0;
    else if (!pgm_n) pw_cnt <= pw_cnt + 1;
    else             pw_cnt <= 0;
  end

  AST_PULSE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgm_n) |-> pw_cnt == PW_CYC); // R3
  AST_PULSE_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    pw_cnt <= PW_CEIL); // R3
  AST_PULSE_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pgm_n && $past(!pgm_n)) |-> $stable(addr)); // R4
  AST_PULSE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !pgm_n |-> (oe_n && !ce_n && dq_oe && vpp_en)); // R7
  AST_NO_READ_UNDER_VPP: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!vpp_en && !dq_oe)); // R5
  AST_SAMPLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev |-> (!oe_n && !ce_n)); // R8
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(pass) && $stable(fail_addr))); // R10
endmodule

bind prog_verify_seq pv_checker #(
  .ADDR_W(ADDR_W), .CLK_FREQ_HZ(CLK_FREQ_HZ),
  .PULSE_US(PULSE_US), .PULSE_MAX_US(PULSE_MAX_US)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .pass(pass), .vpp_en(vpp_en), .ce_n(mem_ce_n), .oe_n(mem_oe_n),
  .pgm_n(mem_pgm_n), .dq_oe(mem_dq_oe), .addr(mem_addr),
  .fail_addr(fail_addr), .rd_ev(rd_ev)
);

// File: tb/sim_prog_verify_seq.sv
`timescale 1ns/1ps
module sim_prog_verify_seq;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;
  localparam int FREQ  = 2_000_000;
  localparam int ACC   = 3;
  // cycle counts restated from the requirements: ceil(FREQ*us/1e6)
  localparam int C_PW  = (FREQ * 20 + 999_999) / 1_000_000;
  localparam int C_SU  = (FREQ * 1 + 999_999) / 1_000_000;
  localparam int C_VP  = C_SU;
  localparam int C_VR  = C_SU;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] src_data, dq_in, dq_out;
  logic [AW-1:0] addr, fail_addr;
  logic dq_oe, ce_n, oe_n, pgm_n, vpp_en, busy, done, pass;

  always #2 clk = ~clk;

  prog_verify_seq #(.ADDR_W(AW), .DATA_W(8), .CLK_FREQ_HZ(FREQ), .ACC_CYC(ACC)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .src_data(src_data), .mem_dq_in(dq_in),
    .mem_addr(addr), .mem_dq_out(dq_out), .mem_dq_oe(dq_oe), .mem_ce_n(ce_n),
    .mem_oe_n(oe_n), .mem_pgm_n(pgm_n), .vpp_en(vpp_en), .busy(busy), .done(done),
    .pass(pass), .fail_addr(fail_addr)
  );

  logic [7:0] seed = 8'h00;
  logic [7:0] pre  [DEPTH];
  logic [7:0] flip [DEPTH];
  logic [7:0] mem  [DEPTH];
  logic mon_clr = 1'b0;

  function automatic logic [7:0] data_of(int a, logic [7:0] s);
    logic [7:0] v;
    v = 8'(a * 37) + s;
    return v ^ 8'h5A;
  endfunction

  assign src_data = data_of(int'(addr), seed);
  assign dq_in = (!ce_n && !oe_n) ? (mem[addr] ^ flip[addr]) : 8'hFF;

  // behavioural memory and bus monitor
  int cyc = 0, chg_cyc, p_start, p_end, v_rise, v_fall, rd_start;
  int npulses, nreads, nxt_p, nxt_r;
  int e_order, e_pw, e_su, e_hold, e_vpp, e_rec, e_oe, e_rd;
  bit hold_pend, rd_act;
  logic pp_pgm, pp_oe, pp_vpp, pp_dqoe;
  logic [AW-1:0] pp_addr;

  always @(negedge clk) begin
    cyc++;
    if (mon_clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] = pre[i];
      chg_cyc = cyc; p_start = 0; p_end = 0; v_rise = 0; v_fall = 0; rd_start = 0;
      npulses = 0; nreads = 0; nxt_p = 0; nxt_r = 0;
      e_order = 0; e_pw = 0; e_su = 0; e_hold = 0; e_vpp = 0; e_rec = 0; e_oe = 0; e_rd = 0;
      hold_pend = 0; rd_act = 0;
    end else begin
      if (addr != pp_addr || dq_oe != pp_dqoe) begin
        if (hold_pend && cyc - p_end < C_SU) e_hold++;
        hold_pend = 0;
        chg_cyc = cyc;
      end
      if (vpp_en && !pp_vpp) v_rise = cyc;
      if (!vpp_en && pp_vpp) begin
        v_fall = cyc;
        if (cyc - p_end < C_VP) e_vpp++;
      end
      if (!pgm_n && pp_pgm) begin
        p_start = cyc;
        if (cyc - chg_cyc < C_SU) e_su++;
        if (int'(addr) != nxt_p) e_order++;
        if (npulses == 0 && cyc - v_rise < C_VP) e_vpp++;
        if (vpp_en) mem[addr] = mem[addr] & dq_out;
        nxt_p++; npulses++;
      end
      if (!pgm_n && (!oe_n || !dq_oe || ce_n)) e_oe++;
      if (pgm_n && !pp_pgm) begin
        if (cyc - p_start != C_PW) e_pw++;
        p_end = cyc; hold_pend = 1;
      end
      if (!oe_n) begin
        if (!pp_oe && nreads == 0 && cyc - v_fall < C_VR) e_rec++;
        if (vpp_en) e_vpp++;
        if (dq_oe) e_oe++;
        if (ce_n) e_rd++;
        if (!rd_act || addr != pp_addr) begin
          if (rd_act && cyc - rd_start < ACC) e_rd++;
          if (int'(addr) != nxt_r) e_rd++;
          nxt_r++; nreads++; rd_start = cyc; rd_act = 1;
        end
      end else if (rd_act) begin
        if (cyc - rd_start < ACC) e_rd++;
        rd_act = 0;
      end
    end
    pp_pgm = pgm_n; pp_oe = oe_n; pp_vpp = vpp_en; pp_dqoe = dq_oe; pp_addr = addr;
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // mode: 0 clean, 1 bad read at 5, 2 bad at 0 and top, 3 bad at top only,
  //       4 unerased byte at 3, 5 clean with a start strobe mid-run
  task automatic run(input logic [7:0] s, input int mode);
    bit exp_pass = 1'b1;
    int exp_fa = 0, t = 0;
    logic hp, hf;
    logic [AW-1:0] ha;
    seed = s;
    for (int i = 0; i < DEPTH; i++) begin pre[i] = 8'hFF; flip[i] = 8'h00; end
    if (mode == 1) flip[5] = 8'h10;
    if (mode == 2) begin flip[0] = 8'h01; flip[DEPTH-1] = 8'h80; end
    if (mode == 3) flip[DEPTH-1] = 8'h04;
    if (mode == 4) pre[3] = 8'h00;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      logic [7:0] d = data_of(i, s);
      if ((((pre[i] & d) ^ flip[i])) != d) begin exp_pass = 1'b0; exp_fa = i; end
    end
    mon_clr = 1'b1;
    @(negedge clk); @(negedge clk);
    mon_clr = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R10 start clears done", int'(done), 0);
    if (mode == 5) begin
      repeat (100) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R11 busy kept after mid-run start", int'(busy), 1);
    end
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R9 run completes", int'(done), 1);
    repeat (2) @(negedge clk);
    chk(npulses == DEPTH && e_order == 0, "R2 one ordered pulse per address", npulses, DEPTH);
    begin
      int bad = 0;
      for (int i = 0; i < DEPTH; i++) if (mem[i] != (pre[i] & data_of(i, s))) bad++;
      chk(bad == 0, "R2 programmed bytes", bad, 0);
    end
    chk(e_pw == 0, "R3 pulse width", e_pw, 0);
    chk(e_su == 0 && e_hold == 0, "R4 setup/hold", e_su + e_hold, 0);
    chk(e_vpp == 0, "R5 voltage request window", e_vpp, 0);
    chk(e_rec == 0, "R6 recovery before read", e_rec, 0);
    chk(e_oe == 0, "R7 bus control in pulse/read", e_oe, 0);
    chk(nreads == DEPTH && e_rd == 0, "R8 read-back order and access", nreads + e_rd, DEPTH);
    chk(pass == exp_pass, "R9 pass flag", int'(pass), int'(exp_pass));
    if (!exp_pass) chk(int'(fail_addr) == exp_fa, "R9 first failing address", int'(fail_addr), exp_fa);
    if (mode == 5) chk(npulses == DEPTH, "R11 no restart", npulses, DEPTH);
    hp = pass; hf = done; ha = fail_addr;
    repeat (30) @(negedge clk);
    chk(pass == hp && done == hf && fail_addr == ha && !busy, "R10 result held",
        int'(fail_addr), int'(ha));
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin pre[i] = 8'hFF; flip[i] = 8'h00; end
    repeat (4) @(negedge clk);
    chk(!busy && !done && !vpp_en && ce_n && oe_n && pgm_n && !dq_oe,
        "R1 idle during reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !vpp_en && ce_n && oe_n && pgm_n && !dq_oe,
        "R1 idle after reset", int'(busy), 0);
    run(8'h00, 0);
    run(8'h33, 0);
    run(8'hC7, 1);
    run(8'h12, 2);
    run(8'h9E, 3);
    run(8'h41, 4);
    run(8'h6B, 5);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800_000;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end
endmodule